// File: doc/BRIEF.md
# Serial Receive Queue with Automatic Flow Control

This block sits between a receive shift register and the host side of a serial port. Each received byte arrives together with three per-character error tags (parity, framing, line-break). It is stored in a 64-entry queue as one 11-bit word. The host sees the oldest stored byte on a read-only holding output. A read strobe retires that byte. The error tags of whichever byte is currently presented are shown in bits 4:2 of a line-status word.

A receive-data interrupt asserts while the fill level is at or above a trigger level that software selects. When automatic flow control is on, the active-low request-to-send output pauses the remote transmitter once the queue fills to the trigger level plus eight. It releases the remote transmitter once the queue drains to the trigger level minus eight. The gap between the two thresholds stops the output from toggling on every byte. With the queue switched off, the block acts as a single-byte holding register.

Top module: `uart_rxq`

## Requirements
- R1: In queue mode (`fifo_en_i`=1) bytes leave in arrival order. `hold_o` shows the oldest stored byte, and a `hold_rd_i` pulse moves to the next one.
- R2: In queue mode at most 64 entries are held. A byte that arrives while 64 are stored is discarded, and the 64 stored bytes remain readable unchanged.
- R3: `stat_o[4:2]` carries the error tags of the byte on `hold_o`, with tag bit 0 at `stat_o[2]`. The field is 0 when the queue is empty.
- R4: Data-ready `stat_o[0]` is 1 exactly when at least one entry is stored. `stat_o[7:5]` are always 0.
- R5: With `fifo_en_i`=0 the block holds a single byte. A second byte arriving before the first is read is discarded and sets the overrun flag.
- R6: `rx_irq_o` is 1 while the fill level is at or above the trigger level. `trig_sel_i` values 0,1,2,3 give trigger levels 1,8,16,28 in queue mode. The level is 1 in single-byte mode. The interrupt drops as soon as the level falls below the trigger.
- R7: Flow control is active when `auto_flow_i`=1 and `rts_ctl_i`=1. While it is active, `rts_n_o` goes high one cycle after the fill level reaches min(trigger+8, 64). It goes low again one cycle after the level falls to max(trigger−8, 0) or lower.
- R8: When flow control is not active, `rts_n_o` equals the inverse of `rts_ctl_i`.
- R9: Overrun `stat_o[1]` is set by any discarded byte and stays set until a `stat_rd_i` pulse. If a discard and a clear fall in the same cycle, the flag stays set.
- R10: A `hold_rd_i` pulse while empty changes nothing. `hold_o` keeps the last byte read, and the next byte written is the next one presented.
- R11: Synchronous active-low reset empties the queue and clears overrun. It sets `hold_o` to 0, drops the interrupt, and drives `rts_n_o` low when flow control is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid_i | input | 1 | A received byte is offered this cycle |
| rx_byte_i | input | 8 | Received data byte |
| rx_err_i | input | 3 | Error tags of the received byte |
| fifo_en_i | input | 1 | 1: 64-entry queue, 0: single-byte holding |
| trig_sel_i | input | 2 | Trigger level select (1, 8, 16, 28) |
| auto_flow_i | input | 1 | Automatic flow-control enable |
| rts_ctl_i | input | 1 | Software request-to-send bit |
| hold_rd_i | input | 1 | Host read strobe of the holding output |
| stat_rd_i | input | 1 | Host read strobe of line status (clears overrun) |
| hold_o | output | 8 | Oldest byte, or last byte read when empty |
| stat_o | output | 8 | Line status: [0] ready, [1] overrun, [4:2] error tags |
| rx_irq_o | output | 1 | Receive-data interrupt |
| rts_n_o | output | 1 | Request-to-send, active low |

## Verification
On every cycle the assertions check several invariants. The fill level never passes 64, and an accepted byte grows it by one. A discard always leaves the overrun flag raised. The interrupt never asserts without ready data. An empty read leaves the holding output still, and reaching the upper threshold under flow control pauses the sender. The bench scenarios cover behaviour that needs history: arrival order and tag pairing across a full queue, the hysteresis path on both the rising and the falling side for every trigger value, the single-byte mode, and recovery from a reset taken while the sender is paused.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  // Error tags per character and line-status width are fixed by the status layout.
  localparam int unsigned ERR_W  = 3;
  localparam int unsigned STAT_W = 8;

  typedef enum logic [1:0] {
    TRIG_ONE     = 2'd0,
    TRIG_EIGHT   = 2'd1,
    TRIG_SIXTEEN = 2'd2,
    TRIG_DEEP    = 2'd3
  } trig_sel_e;

  // Trigger level for a select code; single-byte mode always uses one.
  function automatic int unsigned trig_of(logic [1:0] sel, logic queue_on);
    if (!queue_on) return 1;
    case (trig_sel_e'(sel))
      TRIG_ONE:     return 1;
      TRIG_EIGHT:   return 8;
      TRIG_SIXTEEN: return 16;
      default:      return 28;
    endcase
  endfunction

  // Upper flow threshold, clamped to the queue depth.
  function automatic int unsigned hi_mark(int unsigned trig, int unsigned hyst,
                                          int unsigned depth);
    int unsigned t;
    t = trig + hyst;
    return (t > depth) ? depth : t;
  endfunction

  // Lower flow threshold, clamped at zero.
  function automatic int unsigned lo_mark(int unsigned trig, int unsigned hyst);
    return (trig > hyst) ? (trig - hyst) : 0;
  endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 11
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push_i,
  input  logic                             pop_i,
  input  logic [W-1:0]                     din_i,
  output logic [W-1:0]                     head_o,
  output logic [$clog2(DEPTH+1)-1:0]       count_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count_q;
endmodule

// File: rtl/uart_rxq_flow.sv
module uart_rxq_flow #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned HYST  = 8,
  parameter int unsigned CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] trig_i,
  input  logic          auto_i,
  input  logic          rts_ctl_i,
  output logic          irq_o,
  output logic          rts_n_o,
  output logic          auto_on_o,
  output logic [CW-1:0] hi_o,
  output logic [CW-1:0] lo_o
);
  logic pause_q;

  assign auto_on_o = auto_i & rts_ctl_i;
  assign hi_o = CW'(uart_rxq_pkg::hi_mark(int'(trig_i), HYST, DEPTH));
  assign lo_o = CW'(uart_rxq_pkg::lo_mark(int'(trig_i), HYST));

  assign irq_o = (count_i >= trig_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                         pause_q <= 1'b0;
    else if (!auto_on_o)                pause_q <= 1'b0;
    else if (!pause_q && count_i >= hi_o) pause_q <= 1'b1;
    else if (pause_q && count_i <= lo_o)  pause_q <= 1'b0;
  end

  assign rts_n_o = auto_on_o ? pause_q : ~rts_ctl_i;
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HYST   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rx_valid_i,
  input  logic [DATA_W-1:0]                rx_byte_i,
  input  logic [uart_rxq_pkg::ERR_W-1:0]   rx_err_i,
  input  logic                             fifo_en_i,
  input  logic [1:0]                       trig_sel_i,
  input  logic                             auto_flow_i,
  input  logic                             rts_ctl_i,
  input  logic                             hold_rd_i,
  input  logic                             stat_rd_i,
  output logic [DATA_W-1:0]                hold_o,
  output logic [uart_rxq_pkg::STAT_W-1:0]  stat_o,
  output logic                             rx_irq_o,
  output logic                             rts_n_o
);
  import uart_rxq_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam int unsigned W  = DATA_W + ERR_W;
  localparam int unsigned PAD_W = STAT_W - ERR_W - 2;

  // Named internal events for the checker.
  logic [CW-1:0] count_w, cap_w, trig_w, hi_w, lo_w;
  logic          push_ok, drop_evt, pop_evt, auto_on_w, empty_w;
  logic [W-1:0]  head_w;

  logic [DATA_W-1:0] last_q;
  logic              ovr_q;

  assign cap_w    = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign empty_w  = (count_w == '0);
  assign push_ok  = rx_valid_i && (count_w < cap_w);
  assign drop_evt = rx_valid_i && !(count_w < cap_w);
  assign pop_evt  = hold_rd_i && !empty_w;
  assign trig_w   = CW'(trig_of(trig_sel_i, fifo_en_i));

  uart_rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push_ok),
    .pop_i  (pop_evt),
    .din_i  ({rx_err_i, rx_byte_i}),
    .head_o (head_w),
    .count_o(count_w)
  );

  uart_rxq_flow #(.DEPTH(DEPTH), .HYST(HYST), .CW(CW)) u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_i  (count_w),
    .trig_i   (trig_w),
    .auto_i   (auto_flow_i),
    .rts_ctl_i(rts_ctl_i),
    .irq_o    (rx_irq_o),
    .rts_n_o  (rts_n_o),
    .auto_on_o(auto_on_w),
    .hi_o     (hi_w),
    .lo_o     (lo_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (pop_evt)       last_q <= head_w[DATA_W-1:0];
      if (drop_evt)      ovr_q  <= 1'b1;
      else if (stat_rd_i) ovr_q <= 1'b0;
    end
  end

  assign hold_o = empty_w ? last_q : head_w[DATA_W-1:0];
  assign stat_o = {{PAD_W{1'b0}},
                   (empty_w ? {ERR_W{1'b0}} : head_w[W-1:DATA_W]),
                   ovr_q, ~empty_w};
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     count,
  input logic [CW-1:0]     hi,
  input logic              push_ok,
  input logic              pop_evt,
  input logic              drop_evt,
  input logic              auto_on,
  input logic              rx_valid_i,
  input logic              hold_rd_i,
  input logic [DATA_W-1:0] hold_o,
  input logic [1:0]        stat_low,
  input logic              rx_irq_o,
  input logic              rts_n_o
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_evt) |=> (count == $past(count) + CW'(1)));

  a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> stat_low[1]);

  a_r4_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_low[0] |-> !rx_irq_o);

  a_r10_empty_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rd_i && count == '0 && !rx_valid_i) |=> $stable(hold_o));

  a_r7_pause_at_high: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && count >= hi) |=> (rts_n_o || !auto_on));
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .count     (count_w),
  .hi        (hi_w),
  .push_ok   (push_ok),
  .pop_evt   (pop_evt),
  .drop_evt  (drop_evt),
  .auto_on   (auto_on_w),
  .rx_valid_i(rx_valid_i),
  .hold_rd_i (hold_rd_i),
  .hold_o    (hold_o),
  .stat_low  (stat_o[1:0]),
  .rx_irq_o  (rx_irq_o),
  .rts_n_o   (rts_n_o)
);

// File: tb/uart_rxq_bench.sv
module uart_rxq_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [2:0] rx_err = '0;
  logic       fifo_en = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic       auto_flow = 1'b0;
  logic       rts_ctl = 1'b0;
  logic       hold_rd = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] hold;
  logic [7:0] stat;
  logic       irq, rts_n;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  // Bench-side model
  logic [10:0] mq[$];
  int          lvl;
  bit          paused;
  logic [7:0]  last_rd;

  always #(CLK_P/2) clk = ~clk;

  uart_rxq u_uart_rxq (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .rx_err_i(rx_err), .fifo_en_i(fifo_en), .trig_sel_i(trig_sel),
    .auto_flow_i(auto_flow), .rts_ctl_i(rts_ctl), .hold_rd_i(hold_rd),
    .stat_rd_i(stat_rd), .hold_o(hold), .stat_o(stat), .rx_irq_o(irq),
    .rts_n_o(rts_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_trig(input logic [1:0] s, input logic fe);
    if (!fe) return 1;
    if (s == 2'd0) return 1;
    if (s == 2'd1) return 8;
    if (s == 2'd2) return 16;
    return 28;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    mq.delete(); lvl = 0; paused = 1'b0; last_rd = '0;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    rx_valid = 1'b1; rx_byte = d; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop();
    hold_rd = 1'b1;
    @(negedge clk);
    hold_rd = 1'b0;
  endtask

  // One settle cycle, then check interrupt and flow output against the model.
  task automatic settle_check(input string tag);
    int t, hi, lo;
    @(negedge clk);
    t  = exp_trig(trig_sel, fifo_en);
    hi = (t + 8 > 64) ? 64 : t + 8;
    lo = (t > 8) ? t - 8 : 0;
    if (auto_flow && rts_ctl) begin
      if (!paused && lvl >= hi) paused = 1'b1;
      else if (paused && lvl <= lo) paused = 1'b0;
    end else paused = 1'b0;
    check(irq == (lvl >= t), {"R6 irq ", tag}, irq, lvl >= t);
    if (auto_flow && rts_ctl)
      check(rts_n == paused, {"R7 rts ", tag}, rts_n, paused);
  endtask

  task automatic t_reset_state();
    auto_flow = 1'b1; rts_ctl = 1'b1; fifo_en = 1'b1; trig_sel = 2'd2;
    do_reset();
    check(hold == 8'h00, "R11 hold after reset", hold, 0);
    check(stat == 8'h00, "R11 stat after reset", stat, 0);
    check(irq == 1'b0, "R11 irq after reset", irq, 0);
    check(rts_n == 1'b0, "R11 rts_n after reset", rts_n, 0);
  endtask

  task automatic t_levels(input logic [1:0] sel);
    logic [10:0] w;
    fifo_en = 1'b1; trig_sel = sel; auto_flow = 1'b1; rts_ctl = 1'b1;
    do_reset();
    for (int i = 0; i < 64; i++) begin
      w = {3'((i + sel) % 8), 8'((i * 37 + sel * 11 + 5) % 256)};
      push(w[7:0], w[10:8]);
      mq.push_back(w); lvl++;
      settle_check("fill");
    end
    for (int i = 0; i < 64; i++) begin
      w = mq.pop_front();
      check(hold == w[7:0], "R1 order", hold, w[7:0]);
      check(stat[4:2] == w[10:8], "R3 tags", stat[4:2], w[10:8]);
      check(stat[0] == 1'b1 && stat[7:5] == 3'b000, "R4 ready", stat, 1);
      pop(); lvl--;
      settle_check("drain");
    end
    check(stat == 8'h00, "R4 empty status", stat, 0);
  endtask

  task automatic t_overflow();
    logic [10:0] w;
    fifo_en = 1'b1; trig_sel = 2'd0; auto_flow = 1'b0; rts_ctl = 1'b0;
    do_reset();
    for (int i = 0; i < 64; i++) begin
      w = {3'(i % 8), 8'(i + 100)};
      push(w[7:0], w[10:8]); mq.push_back(w);
    end
    check(stat[1] == 1'b0, "R9 no overrun at full", stat[1], 0);
    push(8'hEE, 3'b111);
    check(stat[1] == 1'b1, "R9 overrun set", stat[1], 1);
    // discard and clear together: flag stays set
    rx_valid = 1'b1; rx_byte = 8'hDD; stat_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; stat_rd = 1'b0;
    check(stat[1] == 1'b1, "R9 set wins over clear", stat[1], 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    check(stat[1] == 1'b0, "R9 overrun cleared", stat[1], 0);
    for (int i = 0; i < 64; i++) begin
      w = mq.pop_front();
      check(hold == w[7:0], "R2 kept bytes", hold, w[7:0]);
      last_rd = w[7:0];
      pop();
    end
    check(stat[0] == 1'b0, "R2 exactly 64 held", stat[0], 0);
  endtask

  task automatic t_empty_read();
    pop();
    check(hold == last_rd, "R10 hold after empty read", hold, last_rd);
    check(stat[0] == 1'b0, "R10 still empty", stat[0], 0);
    push(8'h5A, 3'b010);
    check(hold == 8'h5A, "R10 next byte presented", hold, 8'h5A);
    check(stat[4:2] == 3'b010, "R3 tags of new byte", stat[4:2], 2);
    pop();
    check(stat[0] == 1'b0, "R10 single entry consumed", stat[0], 0);
  endtask

  task automatic t_single();
    fifo_en = 1'b0; trig_sel = 2'd3; auto_flow = 1'b0; rts_ctl = 1'b0;
    do_reset();
    push(8'hA1, 3'b001);
    check(hold == 8'hA1 && stat[0], "R5 single byte held", hold, 8'hA1);
    check(irq == 1'b1, "R6 single-mode trigger is 1", irq, 1);
    push(8'hB2, 3'b000);
    check(stat[1] == 1'b1, "R5 second byte overruns", stat[1], 1);
    check(hold == 8'hA1, "R5 first byte kept", hold, 8'hA1);
    pop();
    check(stat[0] == 1'b0, "R5 empty after one read", stat[0], 0);
    check(irq == 1'b0, "R6 irq drops", irq, 0);
  endtask

  task automatic t_manual_rts();
    fifo_en = 1'b1; auto_flow = 1'b0; rts_ctl = 1'b1;
    do_reset();
    @(negedge clk);
    check(rts_n == 1'b0, "R8 rts bit set", rts_n, 0);
    rts_ctl = 1'b0; @(negedge clk);
    check(rts_n == 1'b1, "R8 rts bit clear", rts_n, 1);
    auto_flow = 1'b1; @(negedge clk);
    check(rts_n == 1'b1, "R8 auto without rts bit", rts_n, 1);
  endtask

  task automatic t_reset_mid();
    fifo_en = 1'b1; trig_sel = 2'd2; auto_flow = 1'b1; rts_ctl = 1'b1;
    do_reset();
    for (int i = 0; i < 30; i++) push(8'(i), 3'b000);
    @(negedge clk);
    check(rts_n == 1'b1, "R7 paused at 30", rts_n, 1);
    do_reset();
    check(rts_n == 1'b0 && stat == 8'h00, "R11 reset while paused", rts_n, 0);
    push(8'h77, 3'b100);
    check(hold == 8'h77, "R11 queue emptied by reset", hold, 8'h77);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    for (int s = 0; s < 4; s++) t_levels(2'(s));
    t_overflow();
    t_empty_read();
    t_single();
    t_manual_rts();
    t_reset_mid();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule